// File: doc/BRIEF.md
# Precomputation-Gated Unsigned Magnitude Comparator

This block compares two unsigned operands of parameterised width and reports whether the first is strictly greater than the second. The result is registered, so it appears one clock after the operands are presented. Operands may change on every clock, and there is no handshake.

To save switching power, each operand is split into its top bit and the rest. The two top bits are captured on every clock. The remaining bits go into wide registers that have a load enable. That enable comes from a small piece of logic that looks only at the two incoming top bits. It loads the wide registers only when the top bits are equal, because that is the only case where the lower bits can change the answer.

When the top bits differ, the wide registers and the lower-bit comparator behind them stay frozen. The result then comes from the registered top bits alone. A registered copy of the enable chooses which of the two paths drives the result.

Top module: `pcmp_gated_compare`

## Requirements
- R1: `gt_o` equals 1 when the unsigned value of `opa_i` is greater than that of `opb_i`, and 0 otherwise. The operands sampled at a rising clock edge set `gt_o` right after that edge, for one cycle of latency.
- R2: The top bit (bit WIDTH-1) of each operand is captured into its own register on every rising edge that is not in reset.
- R3: The lower registers hold bits WIDTH-2..0 of each operand. They load at an edge only when bit WIDTH-1 of `opa_i` equals bit WIDTH-1 of `opb_i`. Otherwise they keep their previous contents unchanged.
- R4: When the captured top bits differ, `gt_o` equals the captured top bit of `opa_i`, whatever the lower operand bits were.
- R5: When the captured top bits are equal, `gt_o` is the strict greater-than of the captured lower bits. Equal operands therefore give 0.
- R6: While `rst_n` is low, all registers are cleared and `gt_o` reads 0. It is still 0 on the first cycle after release.
- R7: The result stays correct when operands whose top bits are equal follow any run of operands whose top bits differ. In that case the frozen lower registers are reloaded in the same edge that captures the new top bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | WIDTH | Operand A, unsigned |
| opb_i | input | WIDTH | Operand B, unsigned |
| gt_o | output | 1 | Registered result of A > B |

## Verification
The hardest case to reach from the ports is a stale lower register that would be used if the reload were late. This needs a run of operands with differing top bits, followed at once by operands with equal top bits and lower bits unlike those last loaded. The stimulus builds such runs on purpose, scrambling the lower bits while the top bits differ. It also mixes in all-ones against zero, equal values and random pairs, and compares every cycle against a behavioural greater-than delayed by one clock.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  // Registered state of the top-bit decision path
  typedef struct packed {
    logic a_top;   // captured top bit of operand A
    logic b_top;   // captured top bit of operand B
    logic lo_live; // lower registers were loaded in this capture
  } top_state_t;

  localparam top_state_t TOP_STATE_RESET = '{a_top: 1'b0, b_top: 1'b0, lo_live: 1'b0};
endpackage

// File: rtl/pcmp_top_stage.sv
module pcmp_top_stage
  import pcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_top_i,
  input  logic       b_top_i,
  output logic       load_en_o,
  output top_state_t state_o
);
  top_state_t state_q;

  // precomputation: lower bits matter only when the top bits tie
  assign load_en_o = ~(a_top_i ^ b_top_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TOP_STATE_RESET;
    else        state_q <= '{a_top: a_top_i, b_top: b_top_i, lo_live: load_en_o};
  end

  assign state_o = state_q;

  assert_top_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (state_q.a_top == $past(a_top_i) && state_q.b_top == $past(b_top_i)));

  assert_live_means_tie_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q.lo_live |-> (state_q.a_top == state_q.b_top));
endmodule

// File: rtl/pcmp_hold_reg.sv
module pcmp_hold_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load_i) q <= d_i;
  end

  assign q_o = q;

  assert_frozen_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) |-> $stable(q));
endmodule

// File: rtl/pcmp_lower_gt.sv
module pcmp_lower_gt #(
  parameter int W = 7
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  // MSB-first scan: a bit decides only if all bits above it tie
  logic gt_c [W+1];
  logic eq_c [W+1];

  assign gt_c[W] = 1'b0;
  assign eq_c[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_scan
    assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & a_i[i] & ~b_i[i]);
    assign eq_c[i] = eq_c[i+1] & ~(a_i[i] ^ b_i[i]);
  end

  assign gt_o = gt_c[0];
endmodule

// File: rtl/pcmp_gated_compare.sv
module pcmp_gated_compare
  import pcmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             gt_o
);
  localparam int LOW_W = WIDTH - 1;

  logic             load_en;
  top_state_t       top_q;
  logic [LOW_W-1:0] a_low_q;
  logic [LOW_W-1:0] b_low_q;
  logic             low_gt;

  pcmp_top_stage u_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_top_i  (opa_i[WIDTH-1]),
    .b_top_i  (opb_i[WIDTH-1]),
    .load_en_o(load_en),
    .state_o  (top_q)
  );

  pcmp_hold_reg #(.W(LOW_W)) u_a_low (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load_en),
    .d_i   (opa_i[LOW_W-1:0]),
    .q_o   (a_low_q)
  );

  pcmp_hold_reg #(.W(LOW_W)) u_b_low (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load_en),
    .d_i   (opb_i[LOW_W-1:0]),
    .q_o   (b_low_q)
  );

  pcmp_lower_gt #(.W(LOW_W)) u_low_cmp (
    .a_i (a_low_q),
    .b_i (b_low_q),
    .gt_o(low_gt)
  );

  // the registered enable picks the path; top bits differ -> A's top bit wins
  assign gt_o = top_q.lo_live ? low_gt : top_q.a_top;

  assert_result_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (gt_o == ($past(opa_i) > $past(opb_i))));

  assert_first_cycle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !gt_o);

  initial begin
    assert_width_ok: assert (WIDTH >= 2);
  end
endmodule

// File: tb/pcmp_gated_compare_tb.sv
module pcmp_gated_compare_tb;
  localparam int WIDTH = 8;
  localparam logic [WIDTH-1:0] ONES = '1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] opa = '0;
  logic [WIDTH-1:0] opb = '0;
  logic             gt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state: result expected after the next rising edge
  bit             exp_gt = 1'b0;
  logic [WIDTH-1:0] held_a = '0;
  logic [WIDTH-1:0] held_b = '0;

  always #2 clk = ~clk;

  pcmp_gated_compare #(.WIDTH(WIDTH)) u_dut (
    .clk  (clk),
    .rst_n(rst_n),
    .opa_i(opa),
    .opb_i(opb),
    .gt_o (gt)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present one operand pair, let one edge pass, then compare at the falling edge
  task automatic step(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    string req;
    opa = a;
    opb = b;
    held_a = a;
    held_b = b;
    exp_gt = (int'(a) > int'(b));
    @(posedge clk);
    @(negedge clk);
    if (held_a[WIDTH-1] != held_b[WIDTH-1]) req = "R1/R4";
    else req = "R1/R5";
    check(gt == exp_gt, req, int'(gt), int'(exp_gt));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    opa = ONES;
    opb = '0;
    repeat (3) @(negedge clk);
    check(gt == 1'b0, "R6 in reset", int'(gt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // first capture after release: ONES vs zero
    check(gt == 1'b1, "R6/R1 first capture", int'(gt), 1);

    // corners
    step(ONES, '0);
    step('0, ONES);
    step(ONES, ONES);
    step('0, '0);
    step(8'h80, 8'h7F);
    step(8'h7F, 8'h80);
    step(8'h55, 8'h54);
    step(8'hD4, 8'hD5);
    step(8'hC3, 8'hC3);

    // R7: load small lower values, then scramble while top bits differ,
    // then tie the top bits with lower bits that disagree with the stale ones
    for (int k = 0; k < 40; k++) begin
      logic [WIDTH-1:0] ra, rb;
      step({1'b0, 7'h01}, {1'b0, 7'h7E});
      for (int j = 0; j < (k % 5) + 1; j++) begin
        ra = $urandom;
        rb = $urandom;
        ra[WIDTH-1] = j[0];
        rb[WIDTH-1] = ~j[0];
        step(ra, rb); // R3: lower bits here must not matter (R4)
      end
      ra = $urandom;
      rb = $urandom;
      rb[WIDTH-1] = ra[WIDTH-1];
      if (k % 3 == 0) rb = ra;
      step(ra, rb); // R7 reload on tie
      check(gt == exp_gt, "R7 reload after frozen run", int'(gt), int'(exp_gt));
    end

    // random, with a bias toward tied top bits and near-equal values
    for (int k = 0; k < 2000; k++) begin
      logic [WIDTH-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      case (k % 4)
        0: rb[WIDTH-1] = ra[WIDTH-1];
        1: rb = ra ^ (WIDTH'(1) << ($urandom % WIDTH));
        default: ;
      endcase
      step(ra, rb);
    end

    // R2: top bits alone drive the result while they differ
    step(8'h80, 8'h00);
    check(gt == 1'b1, "R2 top bit A captured", int'(gt), 1);
    step(8'h00, 8'hFF);
    check(gt == 1'b0, "R2 top bit B captured", int'(gt), 0);

    // R6: reset in the middle clears the result
    opa = ONES;
    opb = '0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(gt == 1'b0, "R6 async clear", int'(gt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(8'h40, 8'h3F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule